// File: doc/BRIEF.md
# Undervoltage Power-Fail and Shutdown Sequencer

This block turns per-cell undervoltage comparator flags into a two-stage protection sequence for a multi-cell battery pack. When any cell stays below the undervoltage level for a warning dwell, an active-low power-fail line warns the host. If the condition then holds for a longer shutdown dwell, the block inhibits discharge, drops the remote supply enable and enters a latched power-down state with its bias-off output asserted.

The power-down state is left only through a wake input. After a wake the whole sequence restarts from the beginning. A forced power-down input gives a ship mode: it latches power-down at once from any state. A separate pack-voltage-low flag holds discharge inhibited without touching the sequence. Both dwells are cycle counts set by parameters. The comparators, analogue timing and output drivers sit outside this block.

Top module: `uv_pf_sequencer`

## Requirements
- R1: Out of reset, with all inputs low: pwr_fail_no = 1, dsg_inhibit_o = 0, supply_en_o = 1, bias_off_o = 0.
- R2: Undervoltage means any bit of cell_uv_i is high. Undervoltage sampled on WARN_CYCLES consecutive rising edges drives pwr_fail_no low right after the last of those edges, and not earlier.
- R3: A cycle in which all cell_uv_i bits are low, before the warning is given, discards the dwell count. The next undervoltage needs a full WARN_CYCLES run again.
- R4: Once warned, undervoltage on SHUT_CYCLES further consecutive edges enters power-down right after the last of them. In power-down, dsg_inhibit_o = 1, supply_en_o = 0, bias_off_o = 1, and pwr_fail_no returns high.
- R5: While warned, an edge that samples no undervoltage returns pwr_fail_no high and stops the shutdown dwell. No power-down follows, and a new warning needs a full WARN_CYCLES run.
- R6: Power-down is latched. It holds whatever cell_uv_i does until wake_i is sampled high with force_pd_i low. After that edge, dsg_inhibit_o = 0, supply_en_o = 1 and bias_off_o = 0.
- R7: After a wake, undervoltage that is still present restarts the full warning dwell from zero.
- R8: force_pd_i high drives dsg_inhibit_o and bias_off_o high in the same cycle, without waiting for an edge. From the next edge it latches power-down from any state. wake_i is ignored while force_pd_i is high.
- R9: pack_low_i high drives dsg_inhibit_o high in the same cycle. It has no effect on the other outputs or on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cell_uv_i | input | NUM_CELLS | Per-cell undervoltage flags, high = below threshold |
| pack_low_i | input | 1 | Pack-voltage-low flag, holds discharge inhibited |
| wake_i | input | 1 | Wake request that releases power-down |
| force_pd_i | input | 1 | Forced power-down (ship mode) |
| pwr_fail_no | output | 1 | Active-low power-fail warning to the host |
| dsg_inhibit_o | output | 1 | Discharge inhibit, high = discharge off |
| supply_en_o | output | 1 | Remote supply enable |
| bias_off_o | output | 1 | Internal bias shutdown request |

## Verification
The hardest situation to reach is an exact edge count. A dip can come one cycle before the warning would have fired. Recovery can come one cycle before shutdown. A wake can arrive while undervoltage is still present. The bench reaches these by holding the cell flags for precise runs of WARN_CYCLES-1 and SHUT_CYCLES-2 edges, and by changing which cell is flagged part-way through a dwell. It also applies wake together with force, then wake alone after force is released. This confirms that the dwell restarts from zero and that wake is rejected while force is held.

// File: rtl/uvps_pkg.sv
package uvps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WARN_WAIT  = 2'd1,
    ST_WARNED     = 2'd2,
    ST_POWER_DOWN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/uvps_uv_any.sv
module uvps_uv_any #(
  parameter int NUM_CELLS = 3
) (
  input  logic [NUM_CELLS-1:0] cell_uv_i,
  output logic                 uv_o
);
  logic [NUM_CELLS:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_or
    assign chain[g+1] = chain[g] | cell_uv_i[g];
  end
  assign uv_o = chain[NUM_CELLS];
endmodule

// File: rtl/uvps_dwell_cnt.sv
module uvps_dwell_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/uvps_seq_ctrl.sv
module uvps_seq_ctrl
  import uvps_pkg::*;
#(
  parameter int WARN_CYCLES = 16,
  parameter int SHUT_CYCLES = 64,
  parameter int CW          = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          uv_i,
  input  logic          wake_i,
  input  logic          force_i,
  input  logic [CW-1:0] cnt_i,
  output seq_state_e    state_o,
  output logic          clr_o,
  output logic          inc_o
);
  localparam logic [CW-1:0] WARN_LAST = CW'(WARN_CYCLES - 1);
  localparam logic [CW-1:0] SHUT_LAST = CW'(SHUT_CYCLES - 1);

  seq_state_e st_d;

  always_comb begin
    st_d  = state_o;
    clr_o = 1'b0;
    inc_o = 1'b0;
    if (force_i) begin
      st_d  = ST_POWER_DOWN;
      clr_o = 1'b1;
    end else begin
      unique case (state_o)
        ST_IDLE: begin
          // counter already zero here; first sample counts as one
          if (uv_i) begin
            st_d  = ST_WARN_WAIT;
            inc_o = 1'b1;
          end
        end
        ST_WARN_WAIT: begin
          if (!uv_i) begin
            st_d  = ST_IDLE;
            clr_o = 1'b1;
          end else if (cnt_i == WARN_LAST) begin
            st_d  = ST_WARNED;
            clr_o = 1'b1;
          end else begin
            inc_o = 1'b1;
          end
        end
        ST_WARNED: begin
          if (!uv_i) begin
            st_d  = ST_IDLE;
            clr_o = 1'b1;
          end else if (cnt_i == SHUT_LAST) begin
            st_d  = ST_POWER_DOWN;
            clr_o = 1'b1;
          end else begin
            inc_o = 1'b1;
          end
        end
        ST_POWER_DOWN: begin
          clr_o = 1'b1;
          if (wake_i) st_d = ST_IDLE;
        end
        default: begin
          st_d  = ST_IDLE;
          clr_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= st_d;
  end
endmodule

// File: rtl/uv_pf_sequencer.sv
module uv_pf_sequencer
  import uvps_pkg::*;
#(
  parameter int NUM_CELLS   = 3,
  parameter int WARN_CYCLES = 16,
  parameter int SHUT_CYCLES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CELLS-1:0] cell_uv_i,
  input  logic                 pack_low_i,
  input  logic                 wake_i,
  input  logic                 force_pd_i,
  output logic                 pwr_fail_no,
  output logic                 dsg_inhibit_o,
  output logic                 supply_en_o,
  output logic                 bias_off_o
);
  localparam int MAX_DWELL = (WARN_CYCLES > SHUT_CYCLES) ? WARN_CYCLES : SHUT_CYCLES;
  localparam int CW        = $clog2(MAX_DWELL + 1);

  logic          uv;
  logic          clr, inc;
  logic [CW-1:0] cnt;
  seq_state_e    st;
  logic          pd_latched;

  uvps_uv_any #(.NUM_CELLS(NUM_CELLS)) u_uv_any (
    .cell_uv_i(cell_uv_i),
    .uv_o     (uv)
  );

  uvps_dwell_cnt #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (inc),
    .cnt_o (cnt)
  );

  uvps_seq_ctrl #(
    .WARN_CYCLES(WARN_CYCLES),
    .SHUT_CYCLES(SHUT_CYCLES),
    .CW         (CW)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .uv_i   (uv),
    .wake_i (wake_i),
    .force_i(force_pd_i),
    .cnt_i  (cnt),
    .state_o(st),
    .clr_o  (clr),
    .inc_o  (inc)
  );

  assign pd_latched    = (st == ST_POWER_DOWN);
  assign pwr_fail_no   = (st != ST_WARNED);
  assign dsg_inhibit_o = pd_latched | force_pd_i | pack_low_i;
  assign supply_en_o   = !pd_latched;
  assign bias_off_o    = pd_latched | force_pd_i;
endmodule

// File: rtl/uvps_chk.sv
module uvps_chk #(
  parameter int NUM_CELLS   = 3,
  parameter int WARN_CYCLES = 16,
  parameter int SHUT_CYCLES = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_CELLS-1:0] cell_uv_i,
  input logic                 pack_low_i,
  input logic                 wake_i,
  input logic                 force_pd_i,
  input logic                 pwr_fail_no,
  input logic                 dsg_inhibit_o,
  input logic                 supply_en_o,
  input logic                 bias_off_o
);
  localparam int RW = $clog2(WARN_CYCLES + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(WARN_CYCLES);

  logic [RW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (cell_uv_i == '0)     run_q <= '0;
    else if (run_q != RUN_MAX)    run_q <= run_q + 1'b1;
  end

  assert_warn_dwell_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_fail_no |-> run_q == RUN_MAX);

  assert_recover_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_fail_no && cell_uv_i == '0 && !force_pd_i) |=> pwr_fail_no);

  assert_pd_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bias_off_o && !wake_i) |=> (bias_off_o && !supply_en_o));

  assert_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_en_o && wake_i && !force_pd_i) |=> (supply_en_o && !bias_off_o));

  assert_force_now_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_pd_i |-> (bias_off_o && dsg_inhibit_o));

  assert_force_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_pd_i |=> !supply_en_o);

  assert_pack_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pack_low_i |-> dsg_inhibit_o);

  assert_pd_outputs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_en_o |-> (bias_off_o && dsg_inhibit_o && pwr_fail_no));
endmodule

bind uv_pf_sequencer uvps_chk #(
  .NUM_CELLS  (NUM_CELLS),
  .WARN_CYCLES(WARN_CYCLES),
  .SHUT_CYCLES(SHUT_CYCLES)
) u_chk (.*);

// File: tb/uv_pf_sequencer_tb.sv
`timescale 1ns/100ps
module uv_pf_sequencer_tb;
  localparam int NC   = 3;
  localparam int WARN = 8;
  localparam int SHUT = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NC-1:0] cell_uv_i = '0;
  logic          pack_low_i = 1'b0;
  logic          wake_i = 1'b0;
  logic          force_pd_i = 1'b0;
  logic          pwr_fail_no, dsg_inhibit_o, supply_en_o, bias_off_o;

  always #2.5 clk_i = ~clk_i;

  uv_pf_sequencer #(.NUM_CELLS(NC), .WARN_CYCLES(WARN), .SHUT_CYCLES(SHUT)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cell_uv_i(cell_uv_i), .pack_low_i(pack_low_i),
    .wake_i(wake_i), .force_pd_i(force_pd_i), .pwr_fail_no(pwr_fail_no),
    .dsg_inhibit_o(dsg_inhibit_o), .supply_en_o(supply_en_o), .bias_off_o(bias_off_o)
  );

  typedef struct {
    logic [3:0] exp;  // {pwr_fail_no, dsg_inhibit, supply_en, bias_off}
    string      tag;
  } item_t;
  item_t q[$];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // spec-level model state
  bit m_pd, m_warned;
  int m_run;

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check({pwr_fail_no, dsg_inhibit_o, supply_en_o, bias_off_o}, it.exp, it.tag);
    end
  end

  task automatic step(input logic [NC-1:0] uv, input bit pl, input bit wk, input bit fp,
                      input string tag);
    item_t it;
    @(negedge clk_i);
    cell_uv_i  = uv;
    pack_low_i = pl;
    wake_i     = wk;
    force_pd_i = fp;
    if (fp) begin
      m_pd = 1; m_warned = 0; m_run = 0;
    end else if (m_pd) begin
      if (wk) m_pd = 0;
      m_run = 0;
    end else if (uv == '0) begin
      m_warned = 0; m_run = 0;
    end else if (!m_warned) begin
      m_run++;
      if (m_run == WARN) begin m_warned = 1; m_run = 0; end
    end else begin
      m_run++;
      if (m_run == SHUT) begin m_pd = 1; m_warned = 0; m_run = 0; end
    end
    it.exp = {!m_warned, (m_pd | fp | pl), !m_pd, (m_pd | fp)};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run(input logic [NC-1:0] uv, input bit pl, input bit wk, input bit fp,
                     input int n, input string tag);
    for (int i = 0; i < n; i++) step(uv, pl, wk, fp, tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    m_pd = 0; m_warned = 0; m_run = 0;
    repeat (3) @(negedge clk_i);
    check({pwr_fail_no, dsg_inhibit_o, supply_en_o, bias_off_o}, 4'b1010, "R1 in reset");
    rst_ni = 1'b1;
    run(3'b000, 0, 0, 0, 3, "R1 idle");
    // dip one edge before the warning would fire
    run(3'b001, 0, 0, 0, WARN - 1, "R3 dwell");
    run(3'b000, 0, 0, 0, 1, "R3 dip");
    run(3'b100, 0, 0, 0, WARN - 1, "R3 fresh dwell");
    run(3'b110, 0, 0, 0, 1, "R2 warn edge");
    // recovery one edge short of shutdown
    run(3'b010, 0, 0, 0, SHUT - 2, "R5 shut dwell");
    run(3'b000, 0, 0, 0, 2, "R5 recover");
    run(3'b010, 0, 0, 0, WARN, "R2 rewarn");
    run(3'b011, 0, 0, 0, SHUT, "R4 shutdown");
    run(3'b101, 0, 0, 0, 5, "R6 latched uv");
    run(3'b000, 0, 0, 0, 5, "R6 latched clear");
    run(3'b001, 0, 1, 0, 1, "R6 wake");
    run(3'b001, 0, 0, 0, WARN + 2, "R7 restart dwell");
    run(3'b000, 0, 0, 0, 2, "R7 clear");
    run(3'b000, 0, 0, 1, 1, "R8 force from idle");
    run(3'b000, 0, 1, 1, 3, "R8 wake ignored under force");
    run(3'b000, 0, 0, 0, 3, "R8 latched after force");
    run(3'b000, 0, 1, 0, 1, "R6 wake after force");
    run(3'b100, 0, 0, 0, WARN - 3, "R8 mid dwell");
    run(3'b100, 0, 0, 1, 1, "R8 force mid dwell");
    run(3'b100, 0, 1, 0, 1, "R8 wake");
    run(3'b000, 1, 0, 0, 3, "R9 pack low idle");
    run(3'b010, 1, 0, 0, WARN + 2, "R9 pack low during warn");
    run(3'b000, 0, 0, 0, 3, "R9 release");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule